// File: doc/BRIEF.md
# Wrapping Burst Column Address Generator

This block sequences the column side of a burst inside a row that is already open. It accepts a read or write command together with a start column. The burst shape comes from mode inputs: the length, the ordering and the read latency. From these the block presents one column address per clock with a valid strobe and a write flag. For reads it also produces an output-drive window that is delayed by the programmed latency, so the data bus is driven exactly while read words are due.

Short bursts of 2, 4 or 8 words stay inside an aligned block of that size. The low address bits count up or are XOR-scrambled, while the upper bits never change. A full-page burst walks the whole row and wraps for as long as no other command arrives. Any new read or write restarts the sequence at once. A precharge cuts the column stream. A burst stop ends only a full-page burst; in the other modes it is flagged as an error. A read issued on the cycle after the last beat keeps both the column stream and the drive window continuous.

Top module: `burst_col_gen`

## Requirements
- R1: On the clock edge that samples `cmd_rd` or `cmd_wr` (edge 0), `col_valid` rises for the following cycle, `col_addr` equals `start_col`, and `col_write` is 1 for a write and 0 for a read.
- R2: With `mode_len` code 0, 1 or 2 the burst has 2, 4 or 8 beats respectively (one per cycle after edges 0 to BL-1). After that, `col_valid` is low and `col_addr` reads 0.
- R3: With `mode_interleave`=0 and a short burst, beat i has its low log2(BL) bits equal to (start+i) mod BL, and the remaining upper bits equal to those of `start_col`.
- R4: With `mode_interleave`=1 and a short burst, beat i has its low log2(BL) bits equal to start XOR i, and its upper bits equal to those of `start_col`.
- R5: With `mode_len` code 3 (full page), beat i is (start+i) mod 2^COL_W whatever the ordering flag, and the burst does not end by itself.
- R6: For a read with latency CL=`mode_cl` (1 to 3), `dq_oe` is high in the cycles after edges CL-1 through CL-2+BL, so the first word is captured CL edges after the command. A write never raises `dq_oe`.
- R7: A read sampled on the edge right after the last beat of a read gives `col_valid` and `dq_oe` with no low cycle between the two bursts.
- R8: A read or write sampled during a burst restarts the sequence from the new start column on the next cycle. When both are sampled together, the write wins.
- R9: `cmd_pre` with no read or write ends column issue: `col_valid` is low after that edge. Read beats already issued still appear on `dq_oe` at their latency.
- R10: `cmd_stop` during a full-page burst ends it, so `col_valid` is low after that edge. If `mode_len` is not 3 when `cmd_stop` is sampled, the burst continues unchanged and `stop_err` is high for exactly the next cycle.
- R11: After reset, `col_valid`, `col_write`, `dq_oe`, `stop_err` and `col_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_pre | input | 1 | Precharge of this bank |
| cmd_stop | input | 1 | Burst stop |
| start_col | input | COL_W | First column of the burst |
| mode_len | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=full page |
| mode_interleave | input | 1 | 0 sequential, 1 interleaved order |
| mode_cl | input | $clog2(MAX_CL+1) | Read latency in cycles, 1..MAX_CL |
| col_addr | output | COL_W | Current column, 0 when idle |
| col_valid | output | 1 | A column is presented this cycle |
| col_write | output | 1 | Current column belongs to a write |
| dq_oe | output | 1 | Drive read data this cycle |
| stop_err | output | 1 | Burst stop seen outside full-page mode |

## Verification
The assertions take for granted that `mode_cl` lies between 1 and MAX_CL. They also assume it stays constant while read beats are still in the latency pipeline, because the drive tap is picked live from it. The burst length and ordering are latched at the command, so only the latency needs this care. The stimulus changes the mode inputs only on the cycle that issues a command, once the previous burst has fully drained. It also never pairs a precharge or stop with a read or write on the same edge, except in the deliberate write-over-read priority case.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_rd,
  input  logic                          cmd_wr,
  input  logic                          cmd_pre,
  input  logic                          cmd_stop,
  input  logic [COL_W-1:0]              start_col,
  input  logic [1:0]                    mode_len,
  input  logic                          mode_interleave,
  input  logic [$clog2(MAX_CL+1)-1:0]   mode_cl,
  output logic [COL_W-1:0]              col_addr,
  output logic                          col_valid,
  output logic                          col_write,
  output logic                          dq_oe,
  output logic                          stop_err
);
  localparam int CLW = $clog2(MAX_CL + 1);
  localparam logic [1:0] LEN_FULL = 2'd3;

  logic             active_q, wr_q, il_q, stop_err_q;
  logic [1:0]       len_q;
  logic [COL_W-1:0] base_q, cnt_q, mask, low, addr;
  logic [MAX_CL-1:1] sh_q;
  logic [MAX_CL-1:0] taps;

  wire new_cmd  = cmd_rd | cmd_wr;
  wire full_q   = (len_q == LEN_FULL);
  wire last     = !full_q && (cnt_q == mask);
  wire rd_now   = active_q & ~wr_q;
  wire stop_ok  = cmd_stop & active_q & full_q;

  always_comb begin
    case (len_q)
      2'd0:    mask = COL_W'(1);
      2'd1:    mask = COL_W'(3);
      2'd2:    mask = COL_W'(7);
      default: mask = '1;
    endcase
  end

  assign low  = (il_q && !full_q) ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign addr = (base_q & ~mask) | (low & mask);
  assign taps = {sh_q, rd_now};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      wr_q       <= 1'b0;
      il_q       <= 1'b0;
      len_q      <= 2'd0;
      base_q     <= '0;
      cnt_q      <= '0;
      sh_q       <= '0;
      stop_err_q <= 1'b0;
    end else begin
      sh_q       <= taps[MAX_CL-2:0];
      stop_err_q <= cmd_stop && (mode_len != LEN_FULL);
      if (new_cmd) begin
        active_q <= 1'b1;
        wr_q     <= cmd_wr;
        il_q     <= mode_interleave;
        len_q    <= mode_len;
        base_q   <= start_col;
        cnt_q    <= '0;
      end else if (cmd_pre || stop_ok || (active_q && last)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q    <= cnt_q + COL_W'(1);
      end
    end
  end

  assign col_valid = active_q;
  assign col_write = active_q & wr_q;
  assign col_addr  = active_q ? addr : '0;
  assign stop_err  = stop_err_q;
  assign dq_oe     = (mode_cl != '0 && mode_cl <= CLW'(MAX_CL)) ? taps[mode_cl - CLW'(1)] : 1'b0;

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr || cmd_rd) |=> (col_valid && col_addr == $past(start_col) && col_write == $past(cmd_wr)));

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_q && cnt_q == mask && !new_cmd) |=> !col_valid);

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !full_q) |-> ((col_addr & ~mask) == (base_q & ~mask)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid) && !$past(new_cmd) && !(il_q && !full_q))
      |-> (((col_addr - $past(col_addr)) & mask) == COL_W'(1)));

  p_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cl == CLW'(2) && $past(mode_cl) == CLW'(2) && dq_oe) |-> $past(col_valid && !col_write));

  p_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && !new_cmd) |=> !col_valid);

  p_stop_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && mode_len != LEN_FULL) |=> stop_err);
endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, cmd_stop = 0;
  logic [7:0] start_col = 0;
  logic [1:0] mode_len = 0;
  logic       mode_interleave = 0;
  logic [1:0] mode_cl = 2'd1;
  logic [7:0] col_addr;
  logic       col_valid, col_write, dq_oe, stop_err;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(8), .MAX_CL(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_stop(cmd_stop), .start_col(start_col), .mode_len(mode_len),
    .mode_interleave(mode_interleave), .mode_cl(mode_cl), .col_addr(col_addr),
    .col_valid(col_valid), .col_write(col_write), .dq_oe(dq_oe), .stop_err(stop_err));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_burst(input bit wr, input int start, input int len, input bit il, input int cl);
    int bl, msk, ea, lo;
    bl  = (len == 0) ? 2 : (len == 1) ? 4 : 8;
    msk = bl - 1;
    @(negedge clk);
    start_col = 8'(start); mode_len = 2'(len); mode_interleave = il; mode_cl = 2'(cl);
    cmd_wr = wr; cmd_rd = !wr;
    @(posedge clk);
    for (int k = 0; k < bl + cl + 1; k++) begin
      @(negedge clk);
      cmd_rd = 0; cmd_wr = 0;
      lo = il ? (start ^ k) : (start + k);
      ea = (k < bl) ? (((start & ~msk) | (lo & msk)) & 255) : 0;
      if (k == 0) check("R1 col_write", int'(col_write), int'(wr));
      check("R2 col_valid", int'(col_valid), int'(k < bl));
      check(il ? "R4 col_addr" : "R3 col_addr", int'(col_addr), ea);
      check("R6 dq_oe", int'(dq_oe), int'(!wr && k >= cl - 1 && k <= cl - 2 + bl));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R11 col_valid", int'(col_valid), 0);
    check("R11 col_addr", int'(col_addr), 0);
    check("R11 dq_oe", int'(dq_oe), 0);
    check("R11 stop_err", int'(stop_err), 0);
    check("R11 col_write", int'(col_write), 0);

    for (int wr = 0; wr < 2; wr++)
      for (int len = 0; len < 3; len++)
        for (int il = 0; il < 2; il++) begin
          for (int s = 0; s < 16; s++) run_burst(wr[0], s, len, il[0], 1 + (s % 3));
          run_burst(wr[0], 250, len, il[0], 3);
        end

    // R5 full page wrap, then R10 honoured stop
    @(negedge clk);
    start_col = 8'd250; mode_len = 2'd3; mode_interleave = 1; mode_cl = 2'd1; cmd_rd = 1;
    @(posedge clk);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cmd_rd = 0;
      check("R5 col_valid", int'(col_valid), 1);
      check("R5 col_addr", int'(col_addr), (250 + k) % 256);
      if (k == 299) cmd_stop = 1;
    end
    @(negedge clk);
    cmd_stop = 0;
    check("R10 stop ends", int'(col_valid), 0);
    check("R10 no err", int'(stop_err), 0);
    check("R10 dq_oe", int'(dq_oe), 0);

    // R10 stop ignored in short mode
    @(negedge clk);
    start_col = 8'd5; mode_len = 2'd1; mode_interleave = 0; mode_cl = 2'd1; cmd_rd = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_rd = 0; cmd_stop = 1;
    check("R10 beat0", int'(col_addr), 5);
    @(negedge clk);
    cmd_stop = 0;
    check("R10 burst continues", int'(col_valid), 1);
    check("R10 addr", int'(col_addr), 6);
    check("R10 stop_err", int'(stop_err), 1);
    @(negedge clk);
    check("R10 stop_err pulse", int'(stop_err), 0);
    check("R10 addr", int'(col_addr), 7);
    repeat (4) @(negedge clk);

    // R7 gapless back-to-back reads
    @(negedge clk);
    start_col = 8'd8; mode_len = 2'd1; mode_cl = 2'd2; cmd_rd = 1;
    @(posedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cmd_rd = 0;
      check("R7 col_valid", int'(col_valid), int'(k < 8));
      check("R7 col_addr", int'(col_addr), (k < 4) ? 8 + k : (k < 8) ? 20 + k - 4 : 0);
      check("R7 dq_oe", int'(dq_oe), int'(k >= 1 && k <= 8));
      if (k == 3) begin cmd_rd = 1; start_col = 8'd20; end
    end

    // R8 interrupt with simultaneous read+write, write wins
    @(negedge clk);
    start_col = 8'd0; mode_len = 2'd2; mode_cl = 2'd3; cmd_rd = 1;
    @(posedge clk);
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      cmd_rd = 0; cmd_wr = 0;
      check("R8 col_valid", int'(col_valid), int'(k < 11));
      check("R8 col_addr", int'(col_addr), (k < 3) ? k : (k < 11) ? 40 + k - 3 : 0);
      check("R8 col_write", int'(col_write), int'(k >= 3 && k < 11));
      check("R8 dq_oe", int'(dq_oe), int'(k >= 2 && k <= 4));
      if (k == 2) begin cmd_rd = 1; cmd_wr = 1; start_col = 8'd40; end
    end

    // R9 precharge cuts issue, pipeline drains
    @(negedge clk);
    start_col = 8'd16; mode_len = 2'd2; mode_cl = 2'd3; cmd_rd = 1;
    @(posedge clk);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      cmd_rd = 0; cmd_pre = 0;
      check("R9 col_valid", int'(col_valid), int'(k < 2));
      check("R9 dq_oe", int'(dq_oe), int'(k >= 2 && k <= 3));
      if (k == 1) cmd_pre = 1;
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule